// File: doc/BRIEF.md
# E1 Timeslot Gating Mask Generator

This block drives three per-timeslot strobes for one E1 link: a receive gate, a transmit gate and a signaling-source select. Each direction has a 32-bit channel mask held in four byte-wide registers. A small parallel register port reads and writes the masks by address. A bit counter, stepped by a bit-time enable and aligned by a frame-sync pulse, walks the 32 timeslots of 8 bits each. At every timeslot start each output takes the mask bit of the channel that begins. The output then holds for the whole channel, so downstream HDLC or UART clocks can be gated without glitches.

A control bit (alternate mode) gives the transmit mask a second role. In this mode the transmit gate is held low. The transmit mask bit of each channel instead drives the signaling-source select: 1 means signaling comes from internal registers, and 0 means it comes from the serial transmit data.

The tracker is a two-state machine. `TRK_HUNT` is entered at reset: the counter is idle and all outputs stay low. `TRK_LOCK` is reached from `TRK_HUNT` on the first frame-sync seen with a bit tick (transition *acquire*). In `TRK_LOCK` the counter counts bit times and wraps after 256 (transition *advance*). A later frame sync with a bit tick restarts it at CH1 (transition *realign*). There is no path back to `TRK_HUNT` except reset.

Top module: `e1_chan_gate`

## Requirements
- R1: The register at receive base 0x2B+k (k = 0..3) holds channels CH(8k+1)..CH(8k+8), with register bit b carrying CH(8k+b+1). The transmit mask is laid out the same way from base 0x22.
- R2: The eight mask addresses and the control address 0x1A read back the last written value. Alternate mode is bit 0 of the control register, and its other bits read 0. Any other address reads 0, and writes to it change nothing.
- R3: Reset clears all mask bytes and the mode bit, drives all three outputs low and puts the tracker in `TRK_HUNT`.
- R4: Before the first frame sync seen together with `bit_tick`, all outputs stay low whatever the masks hold.
- R5: A frame sync seen together with `bit_tick` makes the next bit time bit 0 of CH1. This holds when locking the first time and also in the middle of a frame.
- R6: `rx_gate` equals the receive mask bit of the current channel for all 8 bit times of that channel. The channel is the bit count divided by 8, and after 256 bit times the count wraps to CH1 with no frame sync needed.
- R7: With alternate mode 0, `tx_gate` equals the transmit mask bit of the current channel and `sig_sel` is 0.
- R8: With alternate mode 1, `sig_sel` equals the transmit mask bit of the current channel (1 = register-sourced signaling, 0 = serial input) and `tx_gate` is 0.
- R9: A clock cycle with `bit_tick` low neither advances the bit count nor changes any output.
- R10: A mask or mode write takes effect at the next timeslot start. All outputs change only at timeslot starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| bit_tick | input | 1 | One-cycle enable per E1 bit time |
| fsync | input | 1 | Frame sync, sampled when bit_tick is high |
| reg_addr | input | 8 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| rx_gate | output | 1 | Receive per-channel gate |
| tx_gate | output | 1 | Transmit per-channel gate (normal mode) |
| sig_sel | output | 1 | Signaling-source select (alternate mode) |

## Verification
The bench runs several full frames, each with a different pair of mask patterns. The patterns are chosen to catch specific errors:
- a single set channel at each end of the frame exposes an off-by-one channel index or a wrong wrap;
- alternating patterns expose a swapped bit order within a byte;
- patterns that change at byte edges (CH8/CH9, CH16/CH17) expose a mis-mapped register;
- all-ones and all-zeros separate stuck outputs from real mask following.

Every bit time is compared, so a change in mid-channel is reported. Directed sequences then cover writes in mid-slot, pauses in `bit_tick`, and realignment in mid-frame.

// File: rtl/e1cb_pkg.sv
package e1cb_pkg;
    typedef enum logic {
        TRK_HUNT,
        TRK_LOCK
    } trk_state_t;
endpackage

// File: rtl/e1cb_regfile.sv
module e1cb_regfile #(
    parameter int                NUM_SLOTS = 32,
    parameter int                REG_W     = 8,
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] RX_BASE   = 8'h2B,
    parameter logic [ADDR_W-1:0] TX_BASE   = 8'h22,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h1A,
    parameter int                MODE_BIT  = 0,
    localparam int               NREG      = NUM_SLOTS / REG_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic                 reg_wr,
    input  logic [REG_W-1:0]     reg_wdata,
    output logic [REG_W-1:0]     reg_rdata,
    output logic [NUM_SLOTS-1:0] rx_mask,
    output logic [NUM_SLOTS-1:0] tx_mask,
    output logic                 alt_mode
);
    logic [REG_W-1:0] rx_byte_q [NREG];
    logic [REG_W-1:0] tx_byte_q [NREG];
    logic             mode_q;

    // One storage byte per mask register; the generate index selects the address.
    for (genvar k = 0; k < NREG; k++) begin : g_byte
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                rx_byte_q[k] <= '0;
            end else if (reg_wr && reg_addr == ADDR_W'(RX_BASE + k)) begin
                rx_byte_q[k] <= reg_wdata;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tx_byte_q[k] <= '0;
            end else if (reg_wr && reg_addr == ADDR_W'(TX_BASE + k)) begin
                tx_byte_q[k] <= reg_wdata;
            end
        end

        assign rx_mask[k*REG_W +: REG_W] = rx_byte_q[k];
        assign tx_mask[k*REG_W +: REG_W] = tx_byte_q[k];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
        end else if (reg_wr && reg_addr == CTRL_ADDR) begin
            mode_q <= reg_wdata[MODE_BIT];
        end
    end

    assign alt_mode = mode_q;

    always_comb begin
        reg_rdata = '0;
        for (int k = 0; k < NREG; k++) begin
            if (reg_addr == ADDR_W'(RX_BASE + k)) reg_rdata = rx_byte_q[k];
            if (reg_addr == ADDR_W'(TX_BASE + k)) reg_rdata = tx_byte_q[k];
        end
        if (reg_addr == CTRL_ADDR) reg_rdata[MODE_BIT] = mode_q;
    end
endmodule

// File: rtl/e1cb_slot_tracker.sv
module e1cb_slot_tracker
    import e1cb_pkg::*;
#(
    parameter  int NUM_SLOTS = 32,
    parameter  int SLOT_BITS = 8,
    localparam int FRAME_BITS = NUM_SLOTS * SLOT_BITS,
    localparam int CNT_W      = $clog2(FRAME_BITS),
    localparam int BIT_W      = $clog2(SLOT_BITS),
    localparam int CH_W       = $clog2(NUM_SLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_tick,
    input  logic             fsync,
    output logic             slot_start,
    output logic [CH_W-1:0]  next_ch,
    output logic             tracking,
    output logic [CNT_W-1:0] bit_cnt
);
    trk_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CH_W-1:0]  cur_ch;
    logic             last_bit;

    assign cur_ch   = cnt_q[CNT_W-1:BIT_W];
    assign last_bit = (cnt_q[BIT_W-1:0] == BIT_W'(SLOT_BITS - 1));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TRK_HUNT;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state and outputs
    always_comb begin
        state_d    = state_q;
        cnt_d      = cnt_q;
        slot_start = 1'b0;
        next_ch    = '0;
        unique case (state_q)
            TRK_HUNT: begin
                // acquire
                if (bit_tick && fsync) begin
                    state_d    = TRK_LOCK;
                    cnt_d      = '0;
                    slot_start = 1'b1;
                end
            end
            TRK_LOCK: begin
                if (bit_tick) begin
                    if (fsync) begin
                        // realign
                        cnt_d      = '0;
                        slot_start = 1'b1;
                    end else begin
                        // advance
                        cnt_d = (cnt_q == CNT_W'(FRAME_BITS - 1)) ? '0 : cnt_q + 1'b1;
                        if (last_bit) begin
                            slot_start = 1'b1;
                            next_ch    = (cur_ch == CH_W'(NUM_SLOTS - 1)) ? '0 : cur_ch + 1'b1;
                        end
                    end
                end
            end
            default: state_d = TRK_HUNT;
        endcase
    end

    assign tracking = (state_q == TRK_LOCK);
    assign bit_cnt  = cnt_q;
endmodule

// File: rtl/e1cb_gate_out.sv
module e1cb_gate_out #(
    parameter  int NUM_SLOTS = 32,
    localparam int CH_W      = $clog2(NUM_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 slot_start,
    input  logic [CH_W-1:0]      next_ch,
    input  logic [NUM_SLOTS-1:0] rx_mask,
    input  logic [NUM_SLOTS-1:0] tx_mask,
    input  logic                 alt_mode,
    output logic                 rx_gate,
    output logic                 tx_gate,
    output logic                 sig_sel
);
    logic rx_bit, tx_bit;

    assign rx_bit = rx_mask[next_ch];
    assign tx_bit = tx_mask[next_ch];

    // Outputs load only at a timeslot start, so they hold for the whole channel.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_gate <= 1'b0;
            tx_gate <= 1'b0;
            sig_sel <= 1'b0;
        end else if (slot_start) begin
            rx_gate <= rx_bit;
            tx_gate <= tx_bit & ~alt_mode;
            sig_sel <= tx_bit & alt_mode;
        end
    end
endmodule

// File: rtl/e1_chan_gate.sv
module e1_chan_gate #(
    parameter  int                NUM_SLOTS = 32,
    parameter  int                SLOT_BITS = 8,
    parameter  int                REG_W     = 8,
    parameter  int                ADDR_W    = 8,
    parameter  logic [ADDR_W-1:0] RX_BASE   = 8'h2B,
    parameter  logic [ADDR_W-1:0] TX_BASE   = 8'h22,
    parameter  logic [ADDR_W-1:0] CTRL_ADDR = 8'h1A,
    parameter  int                MODE_BIT  = 0,
    localparam int                CH_W      = $clog2(NUM_SLOTS),
    localparam int                CNT_W     = $clog2(NUM_SLOTS * SLOT_BITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              fsync,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              rx_gate,
    output logic              tx_gate,
    output logic              sig_sel
);
    logic [NUM_SLOTS-1:0] rx_mask, tx_mask;
    logic                 alt_mode;
    logic                 slot_start;
    logic [CH_W-1:0]      next_ch;
    logic                 tracking;
    logic [CNT_W-1:0]     bit_cnt;

    e1cb_regfile #(
        .NUM_SLOTS(NUM_SLOTS), .REG_W(REG_W), .ADDR_W(ADDR_W),
        .RX_BASE(RX_BASE), .TX_BASE(TX_BASE), .CTRL_ADDR(CTRL_ADDR),
        .MODE_BIT(MODE_BIT)
    ) regs_i (
        .clk(clk), .rst_n(rst_n),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .rx_mask(rx_mask), .tx_mask(tx_mask), .alt_mode(alt_mode)
    );

    e1cb_slot_tracker #(
        .NUM_SLOTS(NUM_SLOTS), .SLOT_BITS(SLOT_BITS)
    ) trk_i (
        .clk(clk), .rst_n(rst_n),
        .bit_tick(bit_tick), .fsync(fsync),
        .slot_start(slot_start), .next_ch(next_ch),
        .tracking(tracking), .bit_cnt(bit_cnt)
    );

    e1cb_gate_out #(
        .NUM_SLOTS(NUM_SLOTS)
    ) out_i (
        .clk(clk), .rst_n(rst_n),
        .slot_start(slot_start), .next_ch(next_ch),
        .rx_mask(rx_mask), .tx_mask(tx_mask), .alt_mode(alt_mode),
        .rx_gate(rx_gate), .tx_gate(tx_gate), .sig_sel(sig_sel)
    );
endmodule

// File: rtl/e1cb_checker.sv
module e1cb_checker #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bit_tick,
    input logic             fsync,
    input logic             rx_gate,
    input logic             tx_gate,
    input logic             sig_sel,
    input logic             slot_start,
    input logic             tracking,
    input logic             alt_mode,
    input logic [CNT_W-1:0] bit_cnt
);
    // R10: outputs move only at a timeslot start
    p_hold_mid_slot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_start |=> $stable({rx_gate, tx_gate, sig_sel}));

    // R4: nothing is driven before lock
    p_quiet_in_hunt_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !tracking |-> !(rx_gate || tx_gate || sig_sel));

    // R5: sync with a bit tick lands on bit 0 of CH1
    p_sync_to_ch1_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && fsync) |=> (bit_cnt == '0) && tracking);

    // R9: no bit tick, no count movement
    p_count_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_tick |=> $stable(bit_cnt));

    // R8: the transmit mask has one role at a time
    p_single_role_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_gate && sig_sel));

    // R7: a slot started in normal mode selects no register signaling
    p_normal_no_sel_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_start && !alt_mode) |=> !sig_sel);
endmodule

bind e1_chan_gate e1cb_checker chk_i (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .fsync(fsync),
    .rx_gate(rx_gate), .tx_gate(tx_gate), .sig_sel(sig_sel),
    .slot_start(slot_start), .tracking(tracking), .alt_mode(alt_mode),
    .bit_cnt(bit_cnt)
);

// File: tb/e1_chan_gate_tb_top.sv
module e1_chan_gate_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_tick = 1'b0;
    logic       fsync = 1'b0;
    logic [7:0] reg_addr = 8'h00;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       rx_gate, tx_gate, sig_sel;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    e1_chan_gate dut_i (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .fsync(fsync),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .rx_gate(rx_gate), .tx_gate(tx_gate), .sig_sel(sig_sel)
    );

    // rx mask, tx mask, alternate mode
    localparam logic [64:0] VECS [5] = '{
        {32'h0000_0001, 32'h8000_0000, 1'b0},
        {32'hAAAA_5555, 32'h0F0F_F0F0, 1'b0},
        {32'h0001_8000, 32'h00FF_FF00, 1'b1},
        {32'hFFFF_FFFF, 32'h1234_5678, 1'b1},
        {32'h0000_0000, 32'hFFFF_FFFF, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic edge_step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        edge_step();
        reg_wr    = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [7:0] a, input logic [7:0] exp);
        reg_addr = a;
        #1;
        check(req, {24'h0, reg_rdata}, {24'h0, exp});
    endtask

    task automatic load_masks(input logic [31:0] rx, input logic [31:0] tx, input logic mode);
        for (int k = 0; k < 4; k++) begin
            wr(8'h2B + 8'(k), rx[k*8 +: 8]);
            wr(8'h22 + 8'(k), tx[k*8 +: 8]);
        end
        wr(8'h1A, {7'b0, mode});
    endtask

    task automatic sync_pulse();
        bit_tick = 1'b1;
        fsync    = 1'b1;
        edge_step();
        fsync    = 1'b0;
    endtask

    task automatic check_slot(input int i, input logic [31:0] rx, input logic [31:0] tx, input logic mode);
        int ch;
        ch = (i / 8) % 32;
        check("R6 rx_gate", {31'b0, rx_gate}, {31'b0, rx[ch]});
        if (mode) begin
            check("R8 sig_sel", {31'b0, sig_sel}, {31'b0, tx[ch]});
            check("R8 tx_gate", {31'b0, tx_gate}, 32'h0);
        end else begin
            check("R7 tx_gate", {31'b0, tx_gate}, {31'b0, tx[ch]});
            check("R7 sig_sel", {31'b0, sig_sel}, 32'h0);
        end
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R3: reset state
        edge_step();
        edge_step();
        check("R3 outputs", {29'b0, rx_gate, tx_gate, sig_sel}, 32'h0);
        rd_check("R3 rx byte", 8'h2B, 8'h00);
        rd_check("R3 tx byte", 8'h25, 8'h00);
        rd_check("R3 ctrl", 8'h1A, 8'h00);
        rst_n = 1'b1;
        edge_step();

        // R4: masks set, ticks running, no sync yet
        load_masks(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
        bit_tick = 1'b1;
        for (int i = 0; i < 20; i++) begin
            check("R4 hunt quiet", {29'b0, rx_gate, tx_gate, sig_sel}, 32'h0);
            edge_step();
        end

        // R1 / R2: readback and address decode
        wr(8'h23, 8'h5A);
        rd_check("R1 tx byte1", 8'h23, 8'h5A);
        wr(8'h2E, 8'hC3);
        rd_check("R1 rx byte3", 8'h2E, 8'hC3);
        wr(8'h1A, 8'hFF);
        rd_check("R2 ctrl only mode bit", 8'h1A, 8'h01);
        wr(8'h26, 8'h55);
        rd_check("R2 unmapped 26", 8'h26, 8'h00);
        rd_check("R2 neighbour 25 untouched", 8'h25, 8'hFF);
        rd_check("R2 unmapped 2A", 8'h2A, 8'h00);
        rd_check("R2 unmapped 2F", 8'h2F, 8'h00);
        rd_check("R2 unmapped 00", 8'h00, 8'h00);

        // R1 R5 R6 R7 R8: full frames from the vector table
        for (int v = 0; v < 5; v++) begin
            logic [31:0] rx, tx;
            logic        md;
            {rx, tx, md} = VECS[v];
            load_masks(rx, tx, md);
            sync_pulse();
            for (int i = 0; i <= 256; i++) begin
                check_slot(i, rx, tx, md);
                edge_step();
            end
        end

        // R10: writes in mid-slot act at the next slot start
        load_masks(32'h0, 32'h0000_0006, 1'b0);
        sync_pulse();
        for (int i = 0; i < 24; i++) begin
            logic exp_rx, exp_tx, exp_sel;
            exp_rx  = (i >= 8 && i < 16);
            exp_tx  = (i >= 8 && i < 16);
            exp_sel = (i >= 16);
            check("R10 rx_gate", {31'b0, rx_gate}, {31'b0, exp_rx});
            check("R10 tx_gate", {31'b0, tx_gate}, {31'b0, exp_tx});
            check("R10 sig_sel", {31'b0, sig_sel}, {31'b0, exp_sel});
            if (i == 2) begin
                reg_addr = 8'h2B; reg_wdata = 8'h03; reg_wr = 1'b1;
            end else if (i == 10) begin
                reg_addr = 8'h1A; reg_wdata = 8'h01; reg_wr = 1'b1;
            end else begin
                reg_wr = 1'b0;
            end
            edge_step();
        end
        reg_wr = 1'b0;

        // R9: pause in bit_tick holds count and outputs
        load_masks(32'h0000_0001, 32'h0, 1'b0);
        sync_pulse();
        for (int i = 0; i < 4; i++) begin
            check("R9 before pause", {31'b0, rx_gate}, 32'h1);
            edge_step();
        end
        bit_tick = 1'b0;
        for (int i = 0; i < 10; i++) begin
            check("R9 paused", {31'b0, rx_gate}, 32'h1);
            edge_step();
        end
        bit_tick = 1'b1;
        for (int i = 4; i < 8; i++) begin
            check("R9 resumed CH1", {31'b0, rx_gate}, 32'h1);
            edge_step();
        end
        check("R9 then CH2", {31'b0, rx_gate}, 32'h0);

        // R5: realign in mid-frame
        for (int i = 8; i < 20; i++) edge_step();
        check("R5 in CH3 before realign", {31'b0, rx_gate}, 32'h0);
        sync_pulse();
        for (int i = 0; i < 9; i++) begin
            check("R5 after realign", {31'b0, rx_gate}, {31'b0, (i < 8)});
            edge_step();
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule